// File: doc/BRIEF.md
# Triple-Rail Reset Supervisor Sequencer

This block is the digital decision and timing part of a supervisor that watches three supply rails. Each rail arrives as two comparator flags: one that is high while the rail sits above its upper (rising) threshold, and one that is high while it sits below its lower (falling) threshold. From these flags, an active-low manual-reset request and a power-on reset, the block drives a pair of complementary reset outputs for a processor.

Every input first crosses two synchronizing flops. A per-rail state machine (`RAIL_BAD`, `RAIL_GOOD`) applies hysteresis. It goes to `RAIL_GOOD` on the rising flag (transition *rail_arm*). It goes back to `RAIL_BAD` (transition *rail_trip*) only after the falling flag has been seen for `FILT_CYC` cycles in a row. A brief dip therefore counts for nothing. The sequencer state machine has three states. `SEQ_HOLD` keeps reset asserted. `SEQ_DELAY` keeps reset asserted and counts the release timeout. `SEQ_DONE` releases reset. Its transitions are *start* (HOLD→DELAY when all rails are good and manual reset is high), *expire* (DELAY→DONE after `TIMEOUT_CYC` counting cycles), *abort* (DELAY→HOLD, which clears the count) and *fault* (DONE→HOLD, taken at once). Timing values are parameters in clock cycles. For example, a 200 ms timeout at 50 MHz is 10,000,000 cycles.

Top module: `rail_reset_seq`

## Requirements
- R1: While `por_n` is low, and from the first clock after it, `reset_hi` is 1 and `reset_lo_n` is 0, and every rail is taken as not good.
- R2: Reset stays asserted as long as any rail has not yet shown its rising-threshold flag since power-on or since it last became bad.
- R3: When the last missing condition becomes true at the inputs, reset deasserts after the timeout and no earlier. If the rails are already good and `mr_n` rises at input edge E0, release occurs at edge E0+TIMEOUT_CYC+2. If the last rail's rising flag is sampled at edge E0 (manual reset already high), release occurs at edge E0+TIMEOUT_CYC+3.
- R4: Once reset has been released, a falling flag held for `FILT_CYC` cycles reasserts reset at edge E0+FILT_CYC+2, without waiting for any timeout.
- R5: Each rail has hysteresis. With both flags low, a rail keeps its current good or bad state, and a rising flag while the rail is good has no effect.
- R6: `mr_n` low forces reset asserted from edge E0+2 whatever the rail states, and keeps it asserted for as long as `mr_n` stays low.
- R7: `reset_lo_n` is always the exact inverse of `reset_hi`.
- R8: A falling-flag pulse lasting fewer than `FILT_CYC` consecutive cycles has no effect on the reset outputs.
- R9: If a rail goes bad or `mr_n` goes low during the countdown, the count is discarded. Counting starts again from zero only after all conditions are good again, so the full timeout elapses after the last recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| mr_n | input | 1 | Manual reset request, active low |
| rise_above | input | NUM_RAILS | Per-rail flag: rail above its rising threshold |
| fall_below | input | NUM_RAILS | Per-rail flag: rail below its falling threshold |
| reset_hi | output | 1 | Reset output, active high |
| reset_lo_n | output | 1 | Reset output, active low |

## Verification
The two functions that can meet in one cycle are the release countdown and the fault paths. The bench drops `mr_n` and then trips a rail while the counter is partway through `SEQ_DELAY`. It judges that the release then takes a full timeout measured from the last recovery, and not the remainder of the old count. A second collision pits the glitch filter against a released state. A falling pulse one cycle short of the filter length must leave the outputs untouched, while a pulse of exactly the filter length must reassert reset on the predicted edge. A behavioural cycle model in the bench tracks every edge and compares both outputs on each clock.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

    // Sequencer states: reset held, release countdown, reset released
    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_DELAY = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_e;

    // Per-rail qualification state
    typedef enum logic {
        RAIL_BAD  = 1'b0,
        RAIL_GOOD = 1'b1
    } rail_state_e;

    // Width of a counter that must hold values 0 .. n-1
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
    parameter int unsigned    WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/rstsup_rail.sv
module rstsup_rail
    import rstsup_pkg::*;
#(
    parameter int unsigned FILT_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic fall_i,
    output logic good_o
);

    localparam int unsigned        FCNT_W    = cnt_width(FILT_CYC);
    localparam logic [FCNT_W-1:0]  FCNT_LAST = FCNT_W'(FILT_CYC - 1);

    rail_state_e       state_q, state_d;
    logic [FCNT_W-1:0] fcnt_q, fcnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RAIL_BAD;
            fcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            fcnt_q  <= fcnt_d;
        end
    end

    // Next state and glitch-reject counter
    always_comb begin
        state_d = state_q;
        fcnt_d  = '0;
        unique case (state_q)
            RAIL_BAD: begin
                if (rise_i) begin
                    state_d = RAIL_GOOD;            // rail_arm
                end
            end
            RAIL_GOOD: begin
                if (fall_i) begin
                    if (fcnt_q == FCNT_LAST) begin
                        state_d = RAIL_BAD;         // rail_trip
                    end else begin
                        fcnt_d = fcnt_q + 1'b1;
                    end
                end
            end
            default: state_d = RAIL_BAD;
        endcase
    end

    // Output
    always_comb begin
        good_o = (state_q == RAIL_GOOD);
    end

    AST_RAIL_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!good_o && rise_i) |=> good_o);                                   // R5
    AST_RAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_i && !fall_i) |=> (good_o == $past(good_o)));               // R5
    AST_RAIL_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (good_o && !fall_i) |=> good_o);                                   // R8
    AST_RAIL_TRIP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(good_o) |-> ($past(fcnt_q) == FCNT_LAST));                   // R8

endmodule

// File: rtl/rstsup_seq.sv
module rstsup_seq
    import rstsup_pkg::*;
#(
    parameter int unsigned NUM_RAILS   = 3,
    parameter int unsigned TIMEOUT_CYC = 10_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_good_i,
    input  logic                 mr_ok_i,
    output logic                 assert_hi_o,
    output logic                 assert_lo_n_o
);

    localparam int unsigned       CNT_W    = cnt_width(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             all_ok;

    assign all_ok = (&rail_good_i) & mr_ok_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and release counter
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            SEQ_HOLD: begin
                if (all_ok) begin
                    state_d = SEQ_DELAY;            // start
                end
            end
            SEQ_DELAY: begin
                if (!all_ok) begin
                    state_d = SEQ_HOLD;             // abort
                end else if (cnt_q == CNT_LAST) begin
                    state_d = SEQ_DONE;             // expire
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SEQ_DONE: begin
                if (!all_ok) begin
                    state_d = SEQ_HOLD;             // fault
                end
            end
            default: state_d = SEQ_HOLD;
        endcase
    end

    // Outputs
    always_comb begin
        assert_hi_o   = (state_q != SEQ_DONE);
        assert_lo_n_o = (state_q == SEQ_DONE);
    end

    AST_HOLD_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
        !(&rail_good_i) |=> assert_hi_o);                                  // R2
    AST_RELEASE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(assert_hi_o) |-> ($past(cnt_q) == CNT_LAST));                // R3
    AST_FAULT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!assert_hi_o && !all_ok) |=> assert_hi_o);                        // R4
    AST_MANUAL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_ok_i |=> assert_hi_o);                                         // R6
    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (assert_hi_o != assert_lo_n_o));                                   // R7
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_DELAY && !all_ok) |=> (state_q == SEQ_HOLD && cnt_q == '0)); // R9

endmodule

// File: rtl/rail_reset_seq.sv
module rail_reset_seq
    import rstsup_pkg::*;
#(
    parameter int unsigned NUM_RAILS   = 3,
    parameter int unsigned TIMEOUT_CYC = 10_000_000,
    parameter int unsigned FILT_CYC    = 300
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 mr_n,
    input  logic [NUM_RAILS-1:0] rise_above,
    input  logic [NUM_RAILS-1:0] fall_below,
    output logic                 reset_hi,
    output logic                 reset_lo_n
);

    localparam int unsigned SYNC_W = 2 * NUM_RAILS + 1;

    logic [SYNC_W-1:0]    sync_out;
    logic [NUM_RAILS-1:0] rise_s;
    logic [NUM_RAILS-1:0] fall_s;
    logic                 mr_s;
    logic [NUM_RAILS-1:0] rail_good;

    // Reset value 0 on every bit: manual reset reads as requested, flags idle
    rstsup_sync #(
        .WIDTH   (SYNC_W),
        .RST_VAL ('0)
    ) i_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .async_i ({mr_n, fall_below, rise_above}),
        .sync_o  (sync_out)
    );

    assign rise_s = sync_out[NUM_RAILS-1:0];
    assign fall_s = sync_out[2*NUM_RAILS-1:NUM_RAILS];
    assign mr_s   = sync_out[SYNC_W-1];

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        rstsup_rail #(
            .FILT_CYC (FILT_CYC)
        ) i_rail (
            .clk    (clk),
            .rst_n  (por_n),
            .rise_i (rise_s[g]),
            .fall_i (fall_s[g]),
            .good_o (rail_good[g])
        );
    end

    rstsup_seq #(
        .NUM_RAILS   (NUM_RAILS),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) i_seq (
        .clk           (clk),
        .rst_n         (por_n),
        .rail_good_i   (rail_good),
        .mr_ok_i       (mr_s),
        .assert_hi_o   (reset_hi),
        .assert_lo_n_o (reset_lo_n)
    );

    AST_POR_ASSERTED: assert property (@(posedge clk)
        !por_n |-> (reset_hi && !reset_lo_n));                             // R1

endmodule

// File: tb/test_rail_reset_seq.sv
module test_rail_reset_seq;

    localparam int N = 3;
    localparam int T = 40;
    localparam int F = 5;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         mr_n = 1'b1;
    logic [N-1:0] rise_above = '0;
    logic [N-1:0] fall_below = '0;
    logic         reset_hi;
    logic         reset_lo_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    rail_reset_seq #(
        .NUM_RAILS   (N),
        .TIMEOUT_CYC (T),
        .FILT_CYC    (F)
    ) i_rail_reset_seq (
        .clk        (clk),
        .por_n      (por_n),
        .mr_n       (mr_n),
        .rise_above (rise_above),
        .fall_below (fall_below),
        .reset_hi   (reset_hi),
        .reset_lo_n (reset_lo_n)
    );

    always #10ns clk = ~clk;   // 50 MHz

    // Behavioural cycle model
    int m_r1[N], m_r2[N], m_f1[N], m_f2[N], m_good[N], m_fc[N];
    int m_mr1, m_mr2, m_phase, m_cnt;   // phase: 0 hold, 1 counting, 2 released

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < N; i++) begin
                m_r1[i] = 0; m_r2[i] = 0; m_f1[i] = 0; m_f2[i] = 0;
                m_good[i] = 0; m_fc[i] = 0;
            end
            m_mr1 = 0; m_mr2 = 0; m_phase = 0; m_cnt = 0;
        end else begin
            int ok;
            ok = m_mr2;
            for (int i = 0; i < N; i++) if (m_good[i] == 0) ok = 0;
            if (m_phase == 0) begin
                if (ok != 0) begin m_phase = 1; m_cnt = 0; end
            end else if (m_phase == 1) begin
                if (ok == 0) begin m_phase = 0; m_cnt = 0; end
                else if (m_cnt == T - 1) begin m_phase = 2; m_cnt = 0; end
                else m_cnt++;
            end else begin
                if (ok == 0) m_phase = 0;
            end
            for (int i = 0; i < N; i++) begin
                if (m_good[i] == 0) begin
                    m_fc[i] = 0;
                    if (m_r2[i] != 0) m_good[i] = 1;
                end else if (m_f2[i] != 0) begin
                    if (m_fc[i] == F - 1) begin m_good[i] = 0; m_fc[i] = 0; end
                    else m_fc[i]++;
                end else begin
                    m_fc[i] = 0;
                end
            end
            for (int i = 0; i < N; i++) begin
                m_r2[i] = m_r1[i]; m_f2[i] = m_f1[i];
                m_r1[i] = int'(rise_above[i]); m_f1[i] = int'(fall_below[i]);
            end
            m_mr2 = m_mr1; m_mr1 = int'(mr_n);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the model, and the complement rule
    always @(negedge clk) begin
        if (!done) begin
            int exp_hi;
            exp_hi = (m_phase == 2) ? 0 : 1;
            check(int'(reset_hi) == exp_hi, "R2 model reset_hi", int'(reset_hi), exp_hi);
            check(reset_lo_n === ~reset_hi, "R7 complement", int'(reset_lo_n), int'(~reset_hi));
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_hi(input int exp, input string tag);
        check(int'(reset_hi) == exp, tag, int'(reset_hi), exp);
        check(int'(reset_lo_n) == 1 - exp, tag, int'(reset_lo_n), 1 - exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        wait_n(3);
        expect_hi(1, "R1 during power-on reset");
        por_n = 1'b1;
        wait_n(2);
        expect_hi(1, "R1 after power-on release");

        // R2: rail 2 never arms
        rise_above = 3'b011;
        wait_n(T + 10);
        expect_hi(1, "R2 one rail not armed");

        // R3 + R5: last rail armed by a one-cycle rise pulse
        rise_above = 3'b111;
        wait_n(1);
        rise_above = 3'b000;
        wait_n(T + 2);
        expect_hi(1, "R3 still inside timeout");
        wait_n(1);
        expect_hi(0, "R3 release after timeout (R5 rails held good)");

        // R5: rising flag while good has no effect
        rise_above = 3'b111;
        wait_n(6);
        rise_above = 3'b000;
        expect_hi(0, "R5 rise while good ignored");

        // R8: glitch one cycle short of the filter
        fall_below = 3'b010;
        wait_n(F - 1);
        fall_below = 3'b000;
        wait_n(10);
        expect_hi(0, "R8 short dip ignored");

        // R4: dip of full filter length, immediate reassertion
        fall_below = 3'b010;
        wait_n(F + 2);
        expect_hi(0, "R4 just before trip");
        wait_n(1);
        expect_hi(1, "R4 reasserted without timeout");
        fall_below = 3'b000;

        // R5: rail sits between thresholds, stays bad
        wait_n(T + 10);
        expect_hi(1, "R5 bad rail held bad between thresholds");

        // R9: manual reset pulse in the middle of the countdown
        rise_above = 3'b010;
        wait_n(1);
        rise_above = 3'b000;
        wait_n(T / 2);
        expect_hi(1, "R9 counting");
        mr_n = 1'b0;
        wait_n(1);
        mr_n = 1'b1;
        wait_n(T + 2);
        expect_hi(1, "R9 old count discarded");
        wait_n(1);
        expect_hi(0, "R9 release after full restart");

        // R9: rail fault in the countdown (rail 0)
        mr_n = 1'b0;
        wait_n(4);
        mr_n = 1'b1;
        wait_n(T / 2);
        fall_below = 3'b001;
        wait_n(F + 2);
        fall_below = 3'b000;
        rise_above = 3'b001;
        wait_n(1);
        rise_above = 3'b000;
        wait_n(T + 2);
        expect_hi(1, "R9 rail fault restart pending");
        wait_n(1);
        expect_hi(0, "R9 rail fault full restart");

        // R6: manual reset forces assertion
        mr_n = 1'b0;
        wait_n(2);
        expect_hi(0, "R6 before synchronizer latency");
        wait_n(1);
        expect_hi(1, "R6 forced by manual reset");
        rise_above = 3'b111;
        wait_n(T + 10);
        expect_hi(1, "R6 held while manual reset low");
        rise_above = 3'b000;

        // R3: manual reset release with rails already good
        mr_n = 1'b1;
        wait_n(T + 2);
        expect_hi(1, "R3 manual release inside timeout");
        wait_n(1);
        expect_hi(0, "R3 manual release after timeout");

        // R1: power-on reset mid-run
        @(negedge clk);
        #3ns por_n = 1'b0;
        #2ns;
        expect_hi(1, "R1 asynchronous power-on reset");
        wait_n(2);
        por_n = 1'b1;
        wait_n(T + 10);
        expect_hi(1, "R1 rails not good after power-on");

        finish_run();
    end

endmodule